// File: doc/BRIEF.md
# Single-Bus Microcoded 8-bit Processor

This block is a small 8-bit processor whose datapath shares one internal data bus. It has three general registers, an accumulator, an operand register for the ALU, a sign flag, a program counter, an address register and an instruction register. Its only external data paths are an 8-bit switch input and an 8-bit LED output. Instructions are read from an on-block program ROM whose contents are a parameter. A horizontal control word is computed for each pair of opcode and step, and it sequences every transfer on the bus.

Every instruction, whatever its opcode, takes the same number of clock cycles. Two of these cycles fetch the opcode byte and the rest execute it, with idle steps added where an instruction needs fewer. This fixed cadence lets the surrounding logic, or a test, predict exactly when an input is sampled and when the LED changes. The default program reads five signed values from the switches. It then displays the absolute value of the negative value closest to zero, or 80h if none of the five was negative.

Top module: `sbus_cpu`

## Requirements
- R1: While rst_ni is low, the program counter, all registers, the sign flag and led_o are cleared to 00h, and execution starts at address 00h.
- R2: Every instruction takes exactly 5 clock cycles. Instruction k after reset occupies rising edges 5k to 5k+4. An instruction that samples sw_i or updates led_o does so on edge 5k+2.
- R3: An opcode byte carries the operation in bits 7..4, the source register in bits 3..2 and the destination register in bits 1..0. Register codes are 00 = R0, 01 = R1, 10 = R2.
- R4: Load-immediate (3h), JNS (5h) and JMP (Bh) are two bytes long, and the second byte holds the data or the absolute target. Load-immediate writes that byte to the destination register.
- R5: INC (6h) adds one to the destination register with 8-bit wrap (7Fh to 80h). NEG (Ch) replaces it with its two's complement (01h to FFh, 80h stays 80h). Neither instruction changes the sign flag.
- R6: TEST (4h) loads the sign flag from bit 7 of the destination register. CMP (9h) loads it from bit 7 of the 8-bit wrapped difference source minus destination. No other instruction writes the flag.
- R7: JNS jumps to its target when the sign flag is 0 and otherwise continues at the byte after its two bytes. JMP always jumps. The program counter moves only during fetch or on these jumps.
- R8: IN (7h) writes sw_i into the destination register. OUT (Dh) writes the source register to led_o, which holds that value until the next OUT.
- R9: MOV (Ah) copies the source register into the destination register over the shared bus. At most one source drives that bus in any cycle.
- R10: With the default program, inputs 82h, 01h, 02h, 03h, FEh give 02h on led_o. Five non-negative inputs give 80h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | 8 | Switch value read by IN |
| led_o | output | 8 | Value last written by OUT |

## Verification
The default program is run with three input sets. The first has two negatives that each replace the running best, so both the compare path and the copy path are taken. The second has no negatives, so the compare is never reached and the preset value is negated. The third has only negatives, including 80h itself and a value that must not replace a closer one, so only the sign of the difference decides the result. A second instance runs a crafted program. In it, each OUT reveals one instruction's effect on a fresh LED value: the increment wrap, the negate of 01h and 80h, a comparison whose difference overflows, and the skipped OUTs after taken jumps. Checks placed one cycle before and one cycle after each expected LED change confirm the fixed cadence.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned RSEL_W = 2;
  localparam int unsigned NREG   = 3;
  localparam int unsigned STEPS  = 5;
  localparam int unsigned STEP_W = $clog2(STEPS);

  localparam logic [OP_W-1:0] OP_MVI = 4'h3;
  localparam logic [OP_W-1:0] OP_TST = 4'h4;
  localparam logic [OP_W-1:0] OP_JNS = 4'h5;
  localparam logic [OP_W-1:0] OP_INC = 4'h6;
  localparam logic [OP_W-1:0] OP_IN  = 4'h7;
  localparam logic [OP_W-1:0] OP_CMP = 4'h9;
  localparam logic [OP_W-1:0] OP_MOV = 4'hA;
  localparam logic [OP_W-1:0] OP_JMP = 4'hB;
  localparam logic [OP_W-1:0] OP_NEG = 4'hC;
  localparam logic [OP_W-1:0] OP_OUT = 4'hD;

  typedef enum logic [1:0] {
    ALU_SUB  = 2'b00,
    ALU_PASS = 2'b01,
    ALU_INC  = 2'b10,
    ALU_NEG  = 2'b11
  } alu_e;

  typedef struct packed {
    logic pc_oe;
    logic mem_oe;
    logic rs_oe;
    logic rd_oe;
    logic alu_oe;
    logic sw_oe;
    logic ar_ld;
    logic ir_ld;
    logic pc_inc;
    logic pc_ld;
    logic br_ns;   // resolved against the flag by the sequencer
    logic rd_ld;
    logic ac_ld;
    logic dr_ld;
    logic flag_ld;
    logic led_ld;
    alu_e alu_op;
  } uword_t;

  // Control store: one horizontal word per (opcode, step).
  function automatic uword_t ucode(input logic [OP_W-1:0] op, input logic [STEP_W-1:0] st);
    uword_t u;
    int s;
    u = '0;
    s = int'(st);
    if (s == 0) begin
      u.pc_oe = 1'b1; u.ar_ld = 1'b1;
    end else if (s == 1) begin
      u.mem_oe = 1'b1; u.ir_ld = 1'b1; u.pc_inc = 1'b1;
    end else begin
      case (op)
        OP_MVI, OP_JMP, OP_JNS: begin
          if (s == 2) begin
            u.pc_oe = 1'b1; u.ar_ld = 1'b1;
          end else if (s == 3) begin
            u.mem_oe = 1'b1;
            if (op == OP_MVI) begin
              u.rd_ld = 1'b1; u.pc_inc = 1'b1;
            end else if (op == OP_JMP) u.pc_ld = 1'b1;
            else u.br_ns = 1'b1;
          end
        end
        OP_TST: begin
          if (s == 2) begin
            u.rd_oe = 1'b1; u.ac_ld = 1'b1;
          end else if (s == 3) begin
            u.alu_op = ALU_PASS; u.flag_ld = 1'b1;
          end
        end
        OP_CMP: begin
          if (s == 2) begin
            u.rs_oe = 1'b1; u.ac_ld = 1'b1;
          end else if (s == 3) begin
            u.rd_oe = 1'b1; u.dr_ld = 1'b1;
          end else begin
            u.alu_op = ALU_SUB; u.flag_ld = 1'b1;
          end
        end
        OP_INC, OP_NEG: begin
          u.alu_op = (op == OP_INC) ? ALU_INC : ALU_NEG;
          if (s == 2) begin
            u.rd_oe = 1'b1; u.ac_ld = 1'b1;
          end else if (s == 3) begin
            u.alu_oe = 1'b1; u.rd_ld = 1'b1;
          end
        end
        OP_IN:  if (s == 2) begin u.sw_oe = 1'b1; u.rd_ld = 1'b1; end
        OP_MOV: if (s == 2) begin u.rs_oe = 1'b1; u.rd_ld = 1'b1; end
        OP_OUT: if (s == 2) begin u.rs_oe = 1'b1; u.led_ld = 1'b1; end
        default: ;
      endcase
    end
    return u;
  endfunction
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu import sbus_pkg::*; (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_e          op_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    case (op_i)
      ALU_SUB:  res_o = a_i - b_i;
      ALU_PASS: res_o = a_i;
      ALU_INC:  res_o = a_i + 1'b1;
      default:  res_o = '0 - a_i;
    endcase
  end
endmodule

// File: rtl/sbus_prog_rom.sv
module sbus_prog_rom import sbus_pkg::*; #(
  parameter int unsigned DEPTH = 64,
  parameter logic [0:DEPTH-1][DW-1:0] INIT = '0
) (
  input  logic [DW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  assign data_o = (32'(addr_i) < DEPTH) ? INIT[addr_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/sbus_useq.sv
module sbus_useq import sbus_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic              flag_i,
  output logic [STEP_W-1:0] step_o,
  output uword_t            ctrl_o
);
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else if (step_q == STEP_W'(STEPS-1)) step_q <= '0;
    else step_q <= step_q + 1'b1;
  end

  always_comb begin
    ctrl_o = ucode(op_i, step_q);
    if (ctrl_o.br_ns) begin
      ctrl_o.pc_ld  = ~flag_i;
      ctrl_o.pc_inc = flag_i;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath import sbus_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  uword_t          ctrl_i,
  input  logic [DW-1:0]   mem_i,
  input  logic [DW-1:0]   alu_res_i,
  input  logic [DW-1:0]   sw_i,
  output logic [DW-1:0]   ar_o,
  output logic [OP_W-1:0] op_o,
  output logic [DW-1:0]   ac_o,
  output logic [DW-1:0]   dr_o,
  output logic            flag_o,
  output logic [DW-1:0]   pc_o,
  output logic [DW-1:0]   led_o
);
  logic [DW-1:0] pc_q, ar_q, ir_q, ac_q, dr_q, led_q, bus;
  logic [DW-1:0] gpr_q [NREG];
  logic [DW-1:0] rs_val, rd_val;
  logic [RSEL_W-1:0] rs_idx, rd_idx;
  logic flag_q;

  assign rs_idx = ir_q[2*RSEL_W-1:RSEL_W];
  assign rd_idx = ir_q[RSEL_W-1:0];

  // Unmapped register code reads zero.
  always_comb begin
    rs_val = '0;
    rd_val = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rs_idx == RSEL_W'(i)) rs_val = gpr_q[i];
      if (rd_idx == RSEL_W'(i)) rd_val = gpr_q[i];
    end
  end

  // Wired-OR bus: zero when nothing is enabled.
  assign bus = ({DW{ctrl_i.pc_oe}}  & pc_q)
             | ({DW{ctrl_i.mem_oe}} & mem_i)
             | ({DW{ctrl_i.rs_oe}}  & rs_val)
             | ({DW{ctrl_i.rd_oe}}  & rd_val)
             | ({DW{ctrl_i.alu_oe}} & alu_res_i)
             | ({DW{ctrl_i.sw_oe}}  & sw_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      ar_q   <= '0;
      ir_q   <= '0;
      ac_q   <= '0;
      dr_q   <= '0;
      led_q  <= '0;
      flag_q <= 1'b0;
      for (int i = 0; i < NREG; i++) gpr_q[i] <= '0;
    end else begin
      if (ctrl_i.pc_ld)       pc_q <= bus;
      else if (ctrl_i.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctrl_i.ar_ld)   ar_q   <= bus;
      if (ctrl_i.ir_ld)   ir_q   <= bus;
      if (ctrl_i.ac_ld)   ac_q   <= bus;
      if (ctrl_i.dr_ld)   dr_q   <= bus;
      if (ctrl_i.led_ld)  led_q  <= bus;
      if (ctrl_i.flag_ld) flag_q <= alu_res_i[DW-1];
      for (int i = 0; i < NREG; i++)
        if (ctrl_i.rd_ld && rd_idx == RSEL_W'(i)) gpr_q[i] <= bus;
    end
  end

  assign ar_o   = ar_q;
  assign op_o   = ir_q[DW-1:DW-OP_W];
  assign ac_o   = ac_q;
  assign dr_o   = dr_q;
  assign flag_o = flag_q;
  assign pc_o   = pc_q;
  assign led_o  = led_q;
endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu import sbus_pkg::*; #(
  parameter int unsigned ROM_DEPTH = 64,
  parameter logic [0:ROM_DEPTH-1][DW-1:0] ROM_INIT = '{
    0: 8'h30, 1: 8'hFB,            // R0 = -5 (loop count)
    2: 8'h32, 3: 8'h80,            // R2 = -128 (best so far)
    4: 8'h40,                      // loop: TEST R0
    5: 8'h50, 6: 8'h12,            // JNS done
    7: 8'h60,                      // INC R0
    8: 8'h71,                      // IN R1
    9: 8'h41,                      // TEST R1
    10: 8'h50, 11: 8'h04,          // JNS loop
    12: 8'h99,                     // CMP R2,R1
    13: 8'h50, 14: 8'h04,          // JNS loop
    15: 8'hA6,                     // MOV R1 -> R2
    16: 8'hB0, 17: 8'h04,          // JMP loop
    18: 8'hC2,                     // done: NEG R2
    19: 8'hD8,                     // OUT R2
    20: 8'hB0, 21: 8'h14,          // halt
    default: 8'h00
  }
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] sw_i,
  output logic [DW-1:0] led_o
);
  uword_t            ctrl;
  logic [STEP_W-1:0] step;
  logic [OP_W-1:0]   op;
  logic [DW-1:0]     ar, mem_data, ac, dr, alu_res, pc;
  logic              flag;

  sbus_useq i_useq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .flag_i (flag),
    .step_o (step),
    .ctrl_o (ctrl)
  );

  sbus_prog_rom #(.DEPTH(ROM_DEPTH), .INIT(ROM_INIT)) i_rom (
    .addr_i (ar),
    .data_o (mem_data)
  );

  sbus_alu i_alu (
    .a_i   (ac),
    .b_i   (dr),
    .op_i  (ctrl.alu_op),
    .res_o (alu_res)
  );

  sbus_datapath i_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .mem_i     (mem_data),
    .alu_res_i (alu_res),
    .sw_i      (sw_i),
    .ar_o      (ar),
    .op_o      (op),
    .ac_o      (ac),
    .dr_o      (dr),
    .flag_o    (flag),
    .pc_o      (pc),
    .led_o     (led_o)
  );
endmodule

// File: rtl/sbus_cpu_chk.sv
module sbus_cpu_chk import sbus_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        oe_i,
  input logic              led_ld_i,
  input logic [DW-1:0]     led_i,
  input logic              flag_ld_i,
  input logic              flag_i,
  input logic              pc_chg_i,
  input logic [DW-1:0]     pc_i,
  input logic              rd_ld_i,
  input logic [STEP_W-1:0] step_i
);
  a_r9_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_i));

  a_r8_led_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !led_ld_i |=> $stable(led_i));

  a_r6_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_ld_i |=> $stable(flag_i));

  a_r7_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_chg_i |=> $stable(pc_i));

  a_r2_fetch_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_W'(1)) |=> (pc_i == DW'($past(pc_i) + 1'b1)));

  a_r2_no_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ld_i |-> (step_i >= STEP_W'(2)));

  a_r2_step_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == STEP_W'(STEPS-1)) |=> (step_i == '0));
endmodule

bind sbus_cpu sbus_cpu_chk i_sbus_cpu_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_i      ({ctrl.pc_oe, ctrl.mem_oe, ctrl.rs_oe, ctrl.rd_oe, ctrl.alu_oe, ctrl.sw_oe}),
  .led_ld_i  (ctrl.led_ld),
  .led_i     (led_o),
  .flag_ld_i (ctrl.flag_ld),
  .flag_i    (flag),
  .pc_chg_i  (ctrl.pc_ld | ctrl.pc_inc),
  .pc_i      (pc),
  .rd_ld_i   (ctrl.rd_ld),
  .step_i    (step)
);

// File: tb/test_sbus_cpu.sv
module test_sbus_cpu;
  localparam int unsigned DEPTH = 64;
  localparam logic [0:DEPTH-1][7:0] ALT_PROG = '{
    0: 8'h31, 1: 8'h7F,            // R1 = 7F
    2: 8'hD4,                      // OUT R1
    3: 8'h61,                      // INC R1
    4: 8'hD4,                      // OUT R1
    5: 8'h60,                      // INC R0
    6: 8'hC0,                      // NEG R0
    7: 8'hD0,                      // OUT R0
    8: 8'hC1,                      // NEG R1
    9: 8'hD4,                      // OUT R1
    10: 8'h41,                     // TEST R1
    11: 8'h50, 12: 8'h20,          // JNS (not taken)
    13: 8'h62,                     // INC R2
    14: 8'h50, 15: 8'h20,          // JNS (still not taken)
    16: 8'h96,                     // CMP R1,R2 -> 80-01 wraps to 7F
    17: 8'h50, 18: 8'h16,          // JNS taken
    19: 8'hD8,                     // skipped OUT R2
    22: 8'hA9,                     // MOV R2 -> R1
    23: 8'h70,                     // IN R0
    24: 8'hD0,                     // OUT R0
    25: 8'hD4,                     // OUT R1
    26: 8'h42,                     // TEST R2
    27: 8'h50, 28: 8'h1F,          // JNS taken
    29: 8'hD0,                     // skipped OUT R0
    31: 8'hB0, 32: 8'h23,          // JMP
    33: 8'hD0,                     // skipped OUT R0
    35: 8'h30, 36: 8'h5A,          // R0 = 5A
    37: 8'hD0,                     // OUT R0
    38: 8'hB0, 39: 8'h26,          // halt
    default: 8'h00
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sw_main = 8'h00;
  logic [7:0] sw_alt = 8'h00;
  logic [7:0] led_main, led_alt;
  int cyc;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else cyc <= cyc + 1;

  sbus_cpu i_sbus_cpu (
    .clk_i (clk_i), .rst_ni (rst_ni), .sw_i (sw_main), .led_o (led_main)
  );

  sbus_cpu #(.ROM_DEPTH(DEPTH), .ROM_INIT(ALT_PROG)) i_sbus_cpu_alt (
    .clk_i (clk_i), .rst_ni (rst_ni), .sw_i (sw_alt), .led_o (led_alt)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  task automatic do_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 reset clears led (main)", led_main, 8'h00);
    check("R1 reset clears led (alt)", led_alt, 8'h00);
    rst_ni = 1'b1;
  endtask

  // Instruction index k updates led on edge 5k+2; cyc == e+1 after edge e.
  function automatic int io_edge(input int k);
    return 5 * k + 2;
  endfunction

  task automatic run_search(input string name, input logic [4:0][7:0] v, input logic [7:0] exp);
    int pos;
    int e;
    logic [7:0] best, d;
    do_reset();
    pos = 2;
    best = 8'h80;
    for (int k = 4; k >= 0; k--) begin
      wait_cyc(io_edge(pos + 3));
      sw_main = v[k];
      if (!v[k][7]) pos += 6;
      else begin
        d = best - v[k];
        if (!d[7]) pos += 8;
        else begin
          best = v[k];
          pos += 10;
        end
      end
    end
    e = io_edge(pos + 3);
    wait_cyc(e);
    check({"R2 led still clear before final OUT, ", name}, led_main, 8'h00);
    wait_cyc(e + 1);
    check({"R10 search result, ", name}, led_main, exp);
    check({"R10 search vs model, ", name}, led_main, 8'h00 - best);
  endtask

  task automatic run_alt;
    do_reset();
    sw_alt = 8'h3C;
    wait_cyc(io_edge(1));
    check("R2 led unchanged one cycle before first OUT", led_alt, 8'h00);
    wait_cyc(io_edge(1) + 1);
    check("R4 R3 load-immediate then OUT R1", led_alt, 8'h7F);
    wait_cyc(io_edge(3));
    check("R2 led holds 7F until next OUT", led_alt, 8'h7F);
    wait_cyc(io_edge(3) + 1);
    check("R5 INC wraps 7F to 80", led_alt, 8'h80);
    wait_cyc(io_edge(6) + 1);
    check("R5 NEG of 01 gives FF", led_alt, 8'hFF);
    wait_cyc(io_edge(8));
    check("R8 led holds FF", led_alt, 8'hFF);
    wait_cyc(io_edge(8) + 1);
    check("R5 NEG of 80 stays 80", led_alt, 8'h80);
    wait_cyc(io_edge(17));
    check("R6 R5 R7 CMP wrap clears flag, INC kept flag, OUT R2 skipped", led_alt, 8'h80);
    wait_cyc(io_edge(17) + 1);
    check("R8 IN copies switches to R0", led_alt, 8'h3C);
    wait_cyc(io_edge(18) + 1);
    check("R9 MOV copies R2 into R1", led_alt, 8'h01);
    wait_cyc(io_edge(23));
    check("R7 taken JNS and JMP skip both OUT R0", led_alt, 8'h01);
    wait_cyc(io_edge(23) + 1);
    check("R4 load-immediate after JMP", led_alt, 8'h5A);
    wait_cyc(300);
    check("R8 led holds after last OUT", led_alt, 8'h5A);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    run_search("two replacing negatives", {8'h82, 8'h01, 8'h02, 8'h03, 8'hFE}, 8'h02);
    run_search("no negatives", {8'h00, 8'h7F, 8'h01, 8'h05, 8'h10}, 8'h80);
    run_search("all negatives", {8'h80, 8'hFF, 8'hC0, 8'h81, 8'hFE}, 8'h01);
    run_alt();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end
endmodule